// File: doc/BRIEF.md
# Column-Streamed Linear Detection Array

This block applies a precomputed linear estimator matrix G, one per tone, to a received complex vector y and produces the estimate s = G·y. It contains NLANE identical complex multiply-accumulate lanes, one for each transmitted stream. The matrix is not consumed row by row. Each accepted beat carries one whole column of G, with one complex element per lane, and the matching complex entry of y, which every lane shares. Lane i multiplies its G element by the shared y entry and adds the product into its own accumulator. After NCOL beats, one beat per receive antenna, every lane holds one entry of the estimate.

The product of a beat is registered in a first stage and accumulated in a second, so the array takes a new column on every cycle and the vectors of consecutive tones can follow each other with no idle cycle. A start-of-vector flag realigns the column count at any time. Each accumulator carries enough guard bits to add NCOL full-scale products without wrapping, and the result is clamped to the output width on its way out.

Top module: `col_stream_detector`

## Requirements
- R1: While `rst_n` is low, and after it returns high until the first vector completes, `est_vld` is 0 and every field of `est_re` and `est_im` is 0.
- R2: For each lane i (field `[i*OUT_W +: OUT_W]` of the estimate buses, with lane i's G element in field `[i*WW +: WW]` of the G buses), the estimate is the sum over the NCOL columns j of G[i][j]·y[j] in complex arithmetic: real part Gr·yr − Gi·yi, imaginary part Gr·yi + Gi·yr. All values are two's complement.
- R3: `est_vld` is high for one cycle, two clock edges after the edge that accepts the last column of a vector (the column that holds `col_vld` high), and the estimate is presented in that same cycle.
- R4: A beat with `col_vld` and `col_sov` both high becomes column 0 of a new vector. Partial sums of an unfinished vector are discarded and no result is produced for that vector.
- R5: Once NCOL columns have been accepted, the next accepted column starts a new vector even when `col_sov` is low. Vectors can arrive on consecutive cycles with no gap, and each one produces its own correct result.
- R6: Cycles with `col_vld` low are ignored whatever the data inputs carry. A vector whose columns are separated by such cycles gives the same result as the same vector sent without gaps.
- R7: A sum above 2^(OUT_W−1)−1 is output as 2^(OUT_W−1)−1, and a sum below −2^(OUT_W−1) is output as −2^(OUT_W−1), separately for each real and imaginary part.
- R8: Between two `est_vld` pulses the estimate outputs keep the value of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| col_vld | input | 1 | A column beat is present on this cycle |
| col_sov | input | 1 | The present beat is column 0 of a new vector |
| g_col_re | input | NLANE*WW | Real parts of the G column, lane i in field i |
| g_col_im | input | NLANE*WW | Imaginary parts of the G column, lane i in field i |
| y_re | input | WW | Real part of the shared y entry |
| y_im | input | WW | Imaginary part of the shared y entry |
| est_vld | output | 1 | One-cycle strobe that marks a finished estimate |
| est_re | output | NLANE*OUT_W | Real parts of the estimate, lane i in field i |
| est_im | output | NLANE*OUT_W | Imaginary parts of the estimate, lane i in field i |

## Verification
The bench builds the array with its defaults: four lanes, four columns per vector, 18-bit words and a 24-bit output. With these values small operands keep every sum exact, and full-scale 18-bit operands push a four-term sum far past 24 bits, so both clamp limits can be reached with either sign. Four columns also leave room for an abandoned two-column vector ahead of a restart, and for vectors sent back to back with the start flag present only on the first.

// File: rtl/col_stream_pkg.sv
// Shared types for the column-streamed detection array.
// Assumes nothing beyond the parameters of the top module.
package col_stream_pkg;

    // Position of one accepted column within its vector, carried beside the
    // registered products so that the accumulate stage knows what to do.
    typedef struct packed {
        logic vld;    // a column is in this stage
        logic first;  // it is column 0: start a fresh sum
        logic last;   // it is column NCOL-1: publish the result
    } col_tag_t;

    localparam col_tag_t TAG_IDLE = '{vld: 1'b0, first: 1'b0, last: 1'b0};

endpackage

// File: rtl/col_tracker.sv
// Column tracker: counts accepted columns, tags each one as first and/or
// last of its vector and registers the tag so that it travels in step with
// the lane product registers.
// Assumes NCOL >= 1. A start-of-vector beat always restarts the count.
module col_tracker
    import col_stream_pkg::*;
#(
    parameter int NCOL = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     col_vld,
    input  logic     col_sov,
    output col_tag_t tag_q
);
    localparam int CW = (NCOL > 1) ? $clog2(NCOL) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx;
    logic          is_first;
    logic          is_last;

    // Index of the column on the inputs this cycle.
    always_comb begin
        is_first = col_sov || (cnt_q == '0);
        idx      = col_sov ? '0 : cnt_q;
        is_last  = (idx == CW'(NCOL - 1));
    end

    // Advance the column count on every accepted beat, wrap after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (col_vld)
            cnt_q <= is_last ? '0 : idx + CW'(1);
    end

    // Register the tag alongside the product stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag_q <= TAG_IDLE;
        else
            tag_q <= '{vld: col_vld, first: is_first, last: is_last};
    end

endmodule

// File: rtl/det_lane.sv
// One detection lane: a complex multiplier whose product is registered,
// followed by an accumulator with guard bits and a clamp to OUT_W bits.
// Assumes the tag arrives one cycle after the operands it belongs to, as
// produced by col_tracker.
module det_lane
    import col_stream_pkg::*;
#(
    parameter int WW    = 18,
    parameter int NCOL  = 4,
    parameter int OUT_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    col_vld,
    input  logic signed [WW-1:0]    g_re,
    input  logic signed [WW-1:0]    g_im,
    input  logic signed [WW-1:0]    y_re,
    input  logic signed [WW-1:0]    y_im,
    input  col_tag_t                tag,
    output logic signed [OUT_W-1:0] est_re,
    output logic signed [OUT_W-1:0] est_im
);
    localparam int MW = 2 * WW;                                   // one real product
    localparam int PW = MW + 1;                                   // sum of two products
    localparam int GB = (NCOL > 1) ? $clog2(NCOL) : 0;            // guard bits
    localparam int AW = PW + GB;                                  // accumulator width

    logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [PW-1:0] p_re_q, p_im_q;
    logic signed [AW-1:0] acc_re_q, acc_im_q;
    logic signed [AW-1:0] nxt_re, nxt_im;
    logic signed [OUT_W-1:0] clp_re, clp_im;

    // Four real products of the complex multiply.
    always_comb begin
        m_rr = g_re * y_re;
        m_ii = g_im * y_im;
        m_ri = g_re * y_im;
        m_ir = g_im * y_re;
    end

    // Product stage: combine the real products and register them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_re_q <= '0;
            p_im_q <= '0;
        end else if (col_vld) begin
            p_re_q <= PW'(m_rr) - PW'(m_ii);
            p_im_q <= PW'(m_ri) + PW'(m_ir);
        end
    end

    // Next accumulator value: restart on column 0, otherwise add.
    always_comb begin
        nxt_re = tag.first ? AW'(p_re_q) : acc_re_q + AW'(p_re_q);
        nxt_im = tag.first ? AW'(p_im_q) : acc_im_q + AW'(p_im_q);
    end

    // Accumulate stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_re_q <= '0;
            acc_im_q <= '0;
        end else if (tag.vld) begin
            acc_re_q <= nxt_re;
            acc_im_q <= nxt_im;
        end
    end

    // Clamp to the output width; plain extension when it already fits.
    generate
        if (OUT_W >= AW) begin : g_wide
            always_comb begin
                clp_re = OUT_W'(nxt_re);
                clp_im = OUT_W'(nxt_im);
            end
        end else begin : g_clamp
            localparam logic signed [AW-1:0] HI = {{(AW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
            localparam logic signed [AW-1:0] LO = ~HI;
            always_comb begin
                if (nxt_re > HI)      clp_re = HI[OUT_W-1:0];
                else if (nxt_re < LO) clp_re = LO[OUT_W-1:0];
                else                  clp_re = nxt_re[OUT_W-1:0];
                if (nxt_im > HI)      clp_im = HI[OUT_W-1:0];
                else if (nxt_im < LO) clp_im = LO[OUT_W-1:0];
                else                  clp_im = nxt_im[OUT_W-1:0];
            end
        end
    endgenerate

    // Output register: load the clamped sum when the last column lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est_re <= '0;
            est_im <= '0;
        end else if (tag.vld && tag.last) begin
            est_re <= clp_re;
            est_im <= clp_im;
        end
    end

endmodule

// File: rtl/col_stream_detector.sv
// Column-streamed linear detection array (top). Applies a G column and a
// shared y entry per accepted beat to NLANE lanes; publishes s = G*y two
// edges after the last column of each vector.
// Assumes G and y are two's complement and that vectors are NCOL columns.
module col_stream_detector
    import col_stream_pkg::*;
#(
    parameter int NLANE = 4,
    parameter int NCOL  = 4,
    parameter int WW    = 18,
    parameter int OUT_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   col_vld,
    input  logic                   col_sov,
    input  logic [NLANE*WW-1:0]    g_col_re,
    input  logic [NLANE*WW-1:0]    g_col_im,
    input  logic [WW-1:0]          y_re,
    input  logic [WW-1:0]          y_im,
    output logic                   est_vld,
    output logic [NLANE*OUT_W-1:0] est_re,
    output logic [NLANE*OUT_W-1:0] est_im
);
    col_tag_t tag_q;

    col_tracker #(.NCOL(NCOL)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_vld (col_vld),
        .col_sov (col_sov),
        .tag_q   (tag_q)
    );

    // One lane per stream; the y entry is shared by all of them.
    generate
        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            det_lane #(.WW(WW), .NCOL(NCOL), .OUT_W(OUT_W)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .col_vld (col_vld),
                .g_re    (g_col_re[i*WW +: WW]),
                .g_im    (g_col_im[i*WW +: WW]),
                .y_re    (y_re),
                .y_im    (y_im),
                .tag     (tag_q),
                .est_re  (est_re[i*OUT_W +: OUT_W]),
                .est_im  (est_im[i*OUT_W +: OUT_W])
            );
        end
    endgenerate

    // Result strobe, in step with the lane output registers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            est_vld <= 1'b0;
        else
            est_vld <= tag_q.vld && tag_q.last;
    end

endmodule

// File: rtl/col_stream_detector_chk.sv
// Checker for col_stream_detector, bound to every instance of the top.
// Assumes NCOL >= 1; the single-pulse property applies only for NCOL > 1.
module col_stream_detector_chk #(
    parameter int NLANE = 4,
    parameter int NCOL  = 4,
    parameter int OUT_W = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   col_vld,
    input logic                   est_vld,
    input logic [NLANE*OUT_W-1:0] est_re,
    input logic [NLANE*OUT_W-1:0] est_im
);
    // R1: one cycle of reset clears the strobe and the estimate.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!est_vld && est_re == '0 && est_im == '0));

    // R3: a result always follows an accepted column two edges earlier.
    assert_vld_after_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        est_vld |-> $past(col_vld, 2));

    // R3: with several columns per vector the strobe never lasts two cycles.
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (est_vld && NCOL > 1) |=> !est_vld);

    // R8: the estimate only changes together with the strobe.
    assert_hold_est_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !est_vld |-> ($stable(est_re) && $stable(est_im)));

endmodule

bind col_stream_detector col_stream_detector_chk #(
    .NLANE(NLANE), .NCOL(NCOL), .OUT_W(OUT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .col_vld (col_vld),
    .est_vld (est_vld),
    .est_re  (est_re),
    .est_im  (est_im)
);

// File: tb/tb_col_stream_detector.sv
`timescale 1ns/1ps
module tb_col_stream_detector;
    localparam int NLANE = 4;
    localparam int NCOL  = 4;
    localparam int WW    = 18;
    localparam int OUT_W = 24;
    localparam int MAXV  = 64;
    localparam longint HI = (64'sd1 <<< (OUT_W-1)) - 1;
    localparam longint LO = -(64'sd1 <<< (OUT_W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic col_vld = 1'b0;
    logic col_sov = 1'b0;
    logic [NLANE*WW-1:0] g_col_re = '0;
    logic [NLANE*WW-1:0] g_col_im = '0;
    logic [WW-1:0] y_re = '0;
    logic [WW-1:0] y_im = '0;
    logic est_vld;
    logic [NLANE*OUT_W-1:0] est_re;
    logic [NLANE*OUT_W-1:0] est_im;

    col_stream_detector #(.NLANE(NLANE), .NCOL(NCOL), .WW(WW), .OUT_W(OUT_W)) dut (
        .clk(clk), .rst_n(rst_n), .col_vld(col_vld), .col_sov(col_sov),
        .g_col_re(g_col_re), .g_col_im(g_col_im), .y_re(y_re), .y_im(y_im),
        .est_vld(est_vld), .est_re(est_re), .est_im(est_im)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Operand set of the vector being sent.
    longint cg_re [NLANE][NCOL];
    longint cg_im [NLANE][NCOL];
    longint cy_re [NCOL];
    longint cy_im [NCOL];

    // Expected and captured results.
    longint exp_re [MAXV][NLANE];
    longint exp_im [MAXV][NLANE];
    int     exp_at [MAXV];
    int     exp_n = 0;
    longint cap_re [MAXV][NLANE];
    longint cap_im [MAXV][NLANE];
    int     cap_at [MAXV];
    int     cap_n = 0;
    int     chk_n = 0;

    // Capture every published estimate with its cycle stamp.
    always @(negedge clk) begin
        if (rst_n && est_vld && cap_n < MAXV) begin
            for (int i = 0; i < NLANE; i++) begin
                cap_re[cap_n][i] = longint'($signed(est_re[i*OUT_W +: OUT_W]));
                cap_im[cap_n][i] = longint'($signed(est_im[i*OUT_W +: OUT_W]));
            end
            cap_at[cap_n] = cyc;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic longint clampv(input longint v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    // mode 0: small varied operands; 1: full scale towards +; 2: towards -.
    task automatic fill(input int seed, input int mode);
        longint m = (64'sd1 <<< (WW-1)) - 1;
        for (int j = 0; j < NCOL; j++) begin
            for (int i = 0; i < NLANE; i++) begin
                if (mode == 0) begin
                    cg_re[i][j] = longint'(((seed*131 + i*37 + j*53) % 2001) - 1000);
                    cg_im[i][j] = longint'(((seed*89 + i*61 + j*29 + 7) % 2001) - 1000);
                end else begin
                    cg_re[i][j] = m;
                    cg_im[i][j] = m;
                end
            end
            if (mode == 0) begin
                cy_re[j] = longint'(((seed*17 + j*97 + 3) % 2001) - 1000);
                cy_im[j] = longint'(((seed*43 + j*71 + 11) % 2001) - 1000);
            end else if (mode == 1) begin
                cy_re[j] = m;
                cy_im[j] = -m;
            end else begin
                cy_re[j] = -m;
                cy_im[j] = m;
            end
        end
    endtask

    task automatic drive_col(input int j, input bit sov);
        col_vld = 1'b1;
        col_sov = sov;
        for (int i = 0; i < NLANE; i++) begin
            g_col_re[i*WW +: WW] = WW'(cg_re[i][j]);
            g_col_im[i*WW +: WW] = WW'(cg_im[i][j]);
        end
        y_re = WW'(cy_re[j]);
        y_im = WW'(cy_im[j]);
    endtask

    task automatic drive_junk(input int k);
        col_vld = 1'b0;
        col_sov = (k % 2) == 0;
        g_col_re = {NLANE{WW'(k*4099 + 12345)}};
        g_col_im = {NLANE{WW'(k*7717 + 555)}};
        y_re = WW'(k*3001 + 77);
        y_im = WW'(k*911 + 4242);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            drive_junk(n);
        end
    endtask

    // Send the current operand set as a full vector and record the expectation.
    task automatic push_vec(input bit sov, input int gap);
        for (int j = 0; j < NCOL; j++) begin
            if (j > 0) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    drive_junk(g + j);
                end
            end
            @(negedge clk);
            drive_col(j, sov && j == 0);
            if (j == NCOL - 1) exp_at[exp_n] = cyc + 2;
        end
        for (int i = 0; i < NLANE; i++) begin
            longint sr = 0;
            longint si = 0;
            for (int j = 0; j < NCOL; j++) begin
                sr += cg_re[i][j]*cy_re[j] - cg_im[i][j]*cy_im[j];
                si += cg_re[i][j]*cy_im[j] + cg_im[i][j]*cy_re[j];
            end
            exp_re[exp_n][i] = clampv(sr);
            exp_im[exp_n][i] = clampv(si);
        end
        exp_n++;
    endtask

    task automatic compare_pending(input string req);
        idle(4);
        check(req, "result count", longint'(cap_n), longint'(exp_n));
        for (int k = chk_n; k < exp_n && k < cap_n; k++) begin
            check("R3", $sformatf("vector %0d strobe cycle", k), longint'(cap_at[k]), longint'(exp_at[k]));
            for (int i = 0; i < NLANE; i++) begin
                check(req, $sformatf("vector %0d lane %0d re", k, i), cap_re[k][i], exp_re[k][i]);
                check(req, $sformatf("vector %0d lane %0d im", k, i), cap_im[k][i], exp_im[k][i]);
            end
        end
        chk_n = exp_n;
        cap_n = exp_n;
    endtask

    task automatic t_reset();  // R1
        repeat (3) @(negedge clk);
        check("R1", "est_vld in reset", longint'(est_vld), 0);
        check("R1", "est_re in reset", longint'(est_re != '0), 0);
        @(negedge clk) rst_n = 1'b1;
        idle(3);
        check("R1", "est_vld after reset", longint'(est_vld), 0);
        check("R1", "est_im after reset", longint'(est_im != '0), 0);
        check("R1", "no result before a vector", longint'(cap_n), 0);
    endtask

    task automatic t_basic();  // R2, R3
        fill(1, 0);
        push_vec(1'b1, 0);
        compare_pending("R2");
    endtask

    task automatic t_stream();  // R5
        fill(2, 0); push_vec(1'b1, 0);
        fill(3, 0); push_vec(1'b0, 0);
        fill(4, 0); push_vec(1'b0, 0);
        compare_pending("R5");
    endtask

    task automatic t_gaps();  // R6
        fill(5, 0);
        push_vec(1'b1, 3);
        compare_pending("R6");
    endtask

    task automatic t_restart();  // R4
        fill(6, 0);
        for (int j = 0; j < 2; j++) begin
            @(negedge clk);
            drive_col(j, j == 0);
        end
        fill(7, 0);
        push_vec(1'b1, 0);
        compare_pending("R4");
    endtask

    task automatic t_clamp();  // R7
        fill(0, 1); push_vec(1'b1, 0);
        fill(0, 2); push_vec(1'b1, 0);
        compare_pending("R7");
        check("R7", "positive limit lane 0", cap_re[chk_n-2][0], HI);
        check("R7", "negative limit lane 0", cap_re[chk_n-1][0], LO);
    endtask

    task automatic t_hold();  // R8
        logic [NLANE*OUT_W-1:0] snap_re, snap_im;
        fill(8, 0);
        push_vec(1'b1, 0);
        compare_pending("R8");
        snap_re = est_re;
        snap_im = est_im;
        idle(6);
        check("R8", "est_vld while idle", longint'(est_vld), 0);
        check("R8", "est_re held", longint'(est_re != snap_re), 0);
        check("R8", "est_im held", longint'(est_im != snap_im), 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_stream();
        t_gaps();
        t_restart();
        t_clamp();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule